// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Port

This block is a serial port locked into a clocked shift mode, used to add inputs and outputs through external shift-register chips. A transfer moves one byte, least-significant bit first. The port emits one burst of eight clock pulses on its shift-clock output. The shared data line carries the bits in either direction. The port only ever pulls the data line low or lets it go, so it can share the wire with an external driver through a pull-up.

On the host side there are three items. A transmit-buffer write strobe carries a byte. A one-bit control register holds the receiver enable. A four-flag status register clears itself when it is read. While the receiver is disabled, a transmit write starts a transmission. While it is enabled, a reception starts when the enable is switched on, or when a status read clears a pending receive flag. Switching the receiver off in the middle of a reception stops it at once. The clock returns to its idle-high level and nothing is reported.

The shift-clock half period, in system clocks, is a parameter. A full transfer lasts sixteen half periods.

Top module: `sshift_port`

## Requirements
- R1: Each transfer gives exactly eight pulses on `sclk_o`. Each pulse is low for HALF_DIV clocks and then high for HALF_DIV clocks, so a transfer takes 16*HALF_DIV clocks from its start edge. `sclk_o` stays high while no transfer runs.
- R2: In a transmission, bit k of the byte (bit 0 first) is on the line for the whole of pulse k. The line changes only when `sclk_o` falls.
- R3: The line is modelled as open drain. `sdat_drive_low` is the only line output and is 1 only during a transmission. It stays 0 during receptions and while idle.
- R4: Writing `ctl_wdata`=1 with `ctl_wr` while the receiver is disabled starts a reception. Data is sampled when `sclk_o` rises, first sample into bit 0. At the end of the transfer the byte appears on `rx_byte` and RI (status bit 0) is set.
- R5: With the receiver enabled and the port idle, a status read that finds RI set starts a new reception.
- R6: Writing `ctl_wdata`=0 during a reception aborts it. `sclk_o` is high after that edge, RI is not set and `rx_byte` keeps its old value.
- R7: A transmit write while the receiver is disabled and the port is idle starts a transmission and clears TXE (status bit 2). When the last bit ends, TI (status bit 1) and TXE are set.
- R8: A transmit write while the receiver is enabled, or while a transfer is running, has no effect on the line or on the status.
- R9: `stat_rdata` shows {4'b0, OE, TXE, TI, RI}. A read clears RI, TI and OE after that edge and leaves TXE unchanged. A flag set by a transfer that ends on the same edge as the read stays set.
- R10: If a reception completes while RI is still set, OE (status bit 3) is set and `rx_byte` takes the new byte.
- R11: After reset `sclk_o` is 1, `sdat_drive_low` is 0, `stat_rdata` is 8'h04, `rx_byte` is 0 and `rx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | DATA_W | Byte to transmit |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 1 | New receiver-enable value |
| rx_en | output | 1 | Current receiver-enable bit |
| stat_rd | input | 1 | Status read strobe (clear on read) |
| stat_rdata | output | 8 | Status: bit3 OE, bit2 TXE, bit1 TI, bit0 RI |
| rx_byte | output | DATA_W | Last received byte |
| sclk_o | output | 1 | Shift clock, idles high |
| sdat_drive_low | output | 1 | Pull the data line low when 1, release when 0 |
| sdat_in | input | 1 | Sensed level of the data line |

## Verification
The bench builds the port with HALF_DIV=3 and the default eight-bit byte. A half period of three clocks is odd, so an off-by-one in the divider compare would shift the start and end of a pulse by a visible amount. The transfer is still short enough for many random transmit and receive rounds. An external device model drives the line on each clock pulse. It also captures what the port drives, so bit order, pulse count and the open-drain rule are all observed at the pins. Directed cases place a status read on the exact edge where a transfer ends, and also abort a reception partway through.

// File: rtl/sshift_pkg.sv
package sshift_pkg;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_TX   = 2'd1,
        XF_RX   = 2'd2
    } xfer_mode_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } clk_phase_e;

    // Bit order gives the status layout: bit3 OE, bit2 TXE, bit1 TI, bit0 RI
    typedef struct packed {
        logic oe;
        logic txe;
        logic ti;
        logic ri;
    } port_status_t;

    localparam port_status_t STATUS_RESET = '{oe: 1'b0, txe: 1'b1, ti: 1'b0, ri: 1'b0};

    function automatic logic [7:0] status_to_byte(input port_status_t s);
        return {4'b0000, s};
    endfunction

    function automatic int unsigned safe_clog2(input int unsigned v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/sshift_clkgen.sv
module sshift_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = sshift_pkg::safe_clog2(HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            div_cnt <= '0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick = run && (div_cnt == LAST);

endmodule

// File: rtl/sshift_engine.sv
module sshift_engine
    import sshift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_tx,
    input  logic              start_rx,
    input  logic              abort,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              sdat_in,
    input  logic              tick,
    output xfer_mode_e        mode,
    output logic              sclk_o,
    output logic              drive_low,
    output logic              done_tx,
    output logic              done_rx,
    output logic [DATA_W-1:0] shreg
);
    localparam int BW = safe_clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    clk_phase_e    phase;
    logic [BW-1:0] bit_cnt;
    logic          last_edge;

    assign last_edge = tick && (phase == PH_HIGH) && (bit_cnt == LAST_BIT);
    assign done_tx   = last_edge && (mode == XF_TX);
    assign done_rx   = last_edge && (mode == XF_RX);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= XF_IDLE;
            phase     <= PH_LOW;
            bit_cnt   <= '0;
            sclk_o    <= 1'b1;
            drive_low <= 1'b0;
            shreg     <= '0;
        end else if (abort) begin
            mode      <= XF_IDLE;
            phase     <= PH_LOW;
            bit_cnt   <= '0;
            sclk_o    <= 1'b1;
            drive_low <= 1'b0;
        end else if (start_tx) begin
            mode      <= XF_TX;
            phase     <= PH_LOW;
            bit_cnt   <= '0;
            sclk_o    <= 1'b0;
            shreg     <= tx_data;
            drive_low <= ~tx_data[0];
        end else if (start_rx) begin
            mode      <= XF_RX;
            phase     <= PH_LOW;
            bit_cnt   <= '0;
            sclk_o    <= 1'b0;
            drive_low <= 1'b0;
        end else if (tick && mode != XF_IDLE) begin
            if (phase == PH_LOW) begin
                phase  <= PH_HIGH;
                sclk_o <= 1'b1;
                if (mode == XF_RX) begin
                    shreg <= {sdat_in, shreg[DATA_W-1:1]};
                end
            end else if (bit_cnt == LAST_BIT) begin
                mode      <= XF_IDLE;
                phase     <= PH_LOW;
                bit_cnt   <= '0;
                drive_low <= 1'b0;
            end else begin
                phase   <= PH_LOW;
                bit_cnt <= bit_cnt + 1'b1;
                sclk_o  <= 1'b0;
                if (mode == XF_TX) begin
                    shreg     <= shreg >> 1;
                    drive_low <= ~shreg[1];
                end
            end
        end
    end

endmodule

// File: rtl/sshift_flags.sv
module sshift_flags
    import sshift_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         rd,
    input  logic         tx_accept,
    input  logic         tx_done,
    input  logic         rx_done,
    output port_status_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= STATUS_RESET;
        end else begin
            // Events of this edge take priority over the read clear
            if (rx_done)  st.ri <= 1'b1;
            else if (rd)  st.ri <= 1'b0;

            if (rx_done && st.ri) st.oe <= 1'b1;
            else if (rd)          st.oe <= 1'b0;

            if (tx_done)  st.ti <= 1'b1;
            else if (rd)  st.ti <= 1'b0;

            if (tx_done)        st.txe <= 1'b1;
            else if (tx_accept) st.txe <= 1'b0;
        end
    end

endmodule

// File: rtl/sshift_port.sv
module sshift_port
    import sshift_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              ctl_wr,
    input  logic              ctl_wdata,
    output logic              rx_en,
    input  logic              stat_rd,
    output logic [7:0]        stat_rdata,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sclk_o,
    output logic              sdat_drive_low,
    input  logic              sdat_in
);
    xfer_mode_e        mode;
    port_status_t      st;
    logic              tick, idle, en_rise, en_fall;
    logic              start_tx, start_rx, abort;
    logic              done_tx, done_rx, rx_ok;
    logic [DATA_W-1:0] shreg;

    assign idle     = (mode == XF_IDLE);
    assign en_rise  = ctl_wr &&  ctl_wdata && !rx_en;
    assign en_fall  = ctl_wr && !ctl_wdata &&  rx_en;
    assign start_rx = idle && (en_rise || (stat_rd && st.ri && rx_en && !en_fall));
    assign start_tx = idle && tx_wr && !rx_en && !en_rise;
    assign abort    = en_fall && (mode == XF_RX);
    assign rx_ok    = done_rx && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en   <= 1'b0;
            rx_byte <= '0;
        end else begin
            if (ctl_wr) rx_en <= ctl_wdata;
            if (rx_ok)  rx_byte <= shreg;
        end
    end

    sshift_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
        .clk     (clk),
        .rst     (rst),
        .restart (start_tx || start_rx || abort),
        .run     (!idle),
        .tick    (tick)
    );

    sshift_engine #(.DATA_W(DATA_W)) engine_i (
        .clk       (clk),
        .rst       (rst),
        .start_tx  (start_tx),
        .start_rx  (start_rx),
        .abort     (abort),
        .tx_data   (tx_data),
        .sdat_in   (sdat_in),
        .tick      (tick),
        .mode      (mode),
        .sclk_o    (sclk_o),
        .drive_low (sdat_drive_low),
        .done_tx   (done_tx),
        .done_rx   (done_rx),
        .shreg     (shreg)
    );

    sshift_flags flags_i (
        .clk       (clk),
        .rst       (rst),
        .rd        (stat_rd),
        .tx_accept (start_tx),
        .tx_done   (done_tx),
        .rx_done   (rx_ok),
        .st        (st)
    );

    assign stat_rdata = status_to_byte(st);

endmodule

// File: rtl/sshift_port_chk.sv
module sshift_port_chk
    import sshift_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input xfer_mode_e mode,
    input logic       sclk_o,
    input logic       sdat_drive_low,
    input logic       abort,
    input logic       stat_rd,
    input logic       rx_ok,
    input logic       done_tx,
    input logic       start_tx,
    input logic       tx_wr,
    input logic       rx_en,
    input logic [7:0] stat_rdata
);
    AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode == XF_IDLE) |-> sclk_o); // R1

    AST_TX_BIT_HELD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk_o) && mode == XF_TX) |-> $stable(sdat_drive_low)); // R2

    AST_NO_DRIVE_OUTSIDE_TX: assert property (@(posedge clk) disable iff (rst)
        (mode != XF_TX) |-> !sdat_drive_low); // R3

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
        abort |=> (mode == XF_IDLE && sclk_o)); // R6

    AST_TXE_LOW_WHILE_TX: assert property (@(posedge clk) disable iff (rst)
        (mode == XF_TX) |-> !stat_rdata[2]); // R7

    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && rx_en && mode == XF_IDLE) |=> (mode != XF_TX)); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !rx_ok && !done_tx) |=> (stat_rdata[3] == 1'b0 && stat_rdata[1] == 1'b0 && stat_rdata[0] == 1'b0)); // R9

    AST_READ_KEEPS_TXE: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !done_tx && !start_tx) |=> (stat_rdata[2] == $past(stat_rdata[2]))); // R9

endmodule

bind sshift_port sshift_port_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .mode           (mode),
    .sclk_o         (sclk_o),
    .sdat_drive_low (sdat_drive_low),
    .abort          (abort),
    .stat_rd        (stat_rd),
    .rx_ok          (rx_ok),
    .done_tx        (done_tx),
    .start_tx       (start_tx),
    .tx_wr          (tx_wr),
    .rx_en          (rx_en),
    .stat_rdata     (stat_rdata)
);

// File: tb/sshift_port_tb_top.sv
`timescale 1ns/1ps
module sshift_port_tb_top;
    localparam int HALF = 3;
    localparam int XFER = 16 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       ctl_wr = 1'b0;
    logic       ctl_wdata = 1'b0;
    logic       rx_en;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic [7:0] rx_byte;
    logic       sclk_o;
    logic       sdat_drive_low;
    logic       sdat_in;

    int checks = 0;
    int fails  = 0;
    int unsigned pulses = 0;
    int unsigned drive_cycles = 0;
    int unsigned rx_base = 0;
    logic [7:0]  rx_pat = '0;
    logic [7:0]  tx_cap = '0;
    logic [31:0] rx_off;

    // bench model of the status flags
    logic m_ri = 0, m_ti = 0, m_txe = 1, m_oe = 0;

    always #4 clk = ~clk;

    sshift_port #(.HALF_DIV(HALF), .DATA_W(8)) dut_i (
        .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_data(tx_data),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rx_en(rx_en),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata), .rx_byte(rx_byte),
        .sclk_o(sclk_o), .sdat_drive_low(sdat_drive_low), .sdat_in(sdat_in)
    );

    // external shift device and open-drain line with pull-up
    assign rx_off  = pulses - rx_base;
    assign sdat_in = sdat_drive_low ? 1'b0 : rx_pat[rx_off[2:0]];

    always @(posedge sclk_o) begin
        pulses <= pulses + 1;
        tx_cap <= {~sdat_drive_low, tx_cap[7:1]};
    end

    always @(negedge clk) if (sdat_drive_low) drive_cycles <= drive_cycles + 1;

    function automatic logic [7:0] exp_stat();
        return {4'b0000, m_oe, m_txe, m_ti, m_ri};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic ctl(input logic v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic txw(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_data = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rd(output logic [7:0] s);
        @(negedge clk); s = stat_rdata; stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_tx(input logic [7:0] b, input string req);
        int unsigned p0;
        p0 = pulses;
        txw(b);
        m_txe = 0;
        waitn(XFER + 2);
        m_ti = 1; m_txe = 1;
        chk({req, " tx byte on line"}, tx_cap, b);
        chk({req, " tx pulse count"}, pulses - p0, 8);
        chk({req, " tx status"}, stat_rdata, exp_stat());
    endtask

    task automatic do_rx(input logic [7:0] b, input string req);
        int unsigned p0, d0;
        p0 = pulses; d0 = drive_cycles;
        rx_pat = b; rx_base = pulses;
        ctl(1'b1);
        waitn(XFER + 2);
        if (m_ri) m_oe = 1;
        m_ri = 1;
        chk({req, " rx byte"}, rx_byte, b);
        chk({req, " rx pulse count"}, pulses - p0, 8);
        chk({req, " R3 no drive in rx"}, drive_cycles - d0, 0);
        chk({req, " rx status"}, stat_rdata, exp_stat());
    endtask

    task automatic clear_stat();
        logic [7:0] s;
        rd(s);
        chk("R9 read value", s, exp_stat());
        m_ri = 0; m_ti = 0; m_oe = 0;
        chk("R9 after read", stat_rdata, exp_stat());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [7:0] s;
        logic [7:0] keep;
        int unsigned p0;
        void'($urandom(32'd4242));
        waitn(3);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 sclk idle", sclk_o, 1);
        chk("R11 line released", sdat_drive_low, 0);
        chk("R11 status", stat_rdata, 8'h04);
        chk("R11 rx_byte", rx_byte, 0);
        chk("R11 rx_en", rx_en, 0);

        // R1 pulse shape and R7 TXE during transmit
        txw(8'hA5);
        chk("R1 sclk low after start", sclk_o, 0);
        chk("R7 TXE cleared", stat_rdata[2], 0);
        waitn(HALF);
        chk("R1 sclk high after half", sclk_o, 1);
        waitn(XFER - HALF + 2);
        m_ti = 1;
        chk("R2 tx byte A5", tx_cap, 8'hA5);
        chk("R7 TI and TXE set", stat_rdata, exp_stat());
        clear_stat();

        // R8 write during running transmission ignored
        p0 = pulses;
        txw(8'h3C);
        m_txe = 0;
        waitn(4);
        txw(8'hFF);
        waitn(XFER);
        m_ti = 1; m_txe = 1;
        chk("R8 busy write ignored", tx_cap, 8'h3C);
        chk("R1 pulse count", pulses - p0, 8);
        clear_stat();

        // R4 reception on enable rise
        do_rx(8'hC3, "R4");

        // R8 write with receiver enabled ignored
        p0 = pulses;
        txw(8'h55);
        chk("R8 TXE kept while enabled", stat_rdata[2], 1);
        waitn(XFER);
        chk("R8 no pulses while enabled", pulses - p0, 0);

        // R5 status read clears RI and starts a reception
        rx_pat = 8'h5A; rx_base = pulses;
        rd(s);
        chk("R5 read value", s, exp_stat());
        m_ri = 0;
        waitn(XFER + 2);
        m_ri = 1;
        chk("R5 rx byte", rx_byte, 8'h5A);
        chk("R5 status", stat_rdata, exp_stat());

        // R10 overrun
        ctl(1'b0);
        do_rx(8'h96, "R10");
        chk("R10 OE set", stat_rdata, 8'h0D);
        ctl(1'b0);
        clear_stat();

        // R6 abort mid-reception
        keep = rx_byte;
        p0 = pulses;
        rx_pat = 8'hFF; rx_base = pulses;
        ctl(1'b1);
        waitn(6 * HALF);
        ctl(1'b0);
        chk("R6 sclk high after abort", sclk_o, 1);
        waitn(XFER);
        chk("R6 no RI", stat_rdata, exp_stat());
        chk("R6 rx_byte kept", rx_byte, keep);
        chk("R6 partial pulses", (pulses - p0) < 8, 1);

        // R9 read on the completion edge: set wins
        txw(8'h81);
        waitn(XFER - 2);
        rd(s);
        chk("R9 read before done", s, 8'h00);
        m_ti = 1; m_txe = 1;
        chk("R9 set beats clear", stat_rdata, exp_stat());
        chk("R2 tx byte 81", tx_cap, 8'h81);
        clear_stat();

        // random mix of transfers
        for (int i = 0; i < 24; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if ($urandom % 2 == 0) begin
                do_tx(b, "R2 R7 random");
            end else begin
                do_rx(b, "R4 random");
                ctl(1'b0);
            end
            clear_stat();
        end

        finish_up();
    end

endmodule